// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block keeps the control and status byte of each channel of a multi-channel DMA controller. Software reaches the bytes over a plain register bus. A write carries a data byte and a bit mask, and only the bits selected by the mask change, so the same port serves whole-byte writes and single-bit writes. A read returns the selected byte one cycle after the request. Each channel's transfer engine sends a one-cycle terminal-count pulse when its transfer finishes. A shared non-maskable interrupt input stops every channel at once.

For each channel the block drives four outputs. The enable level and the request-accept qualifier tell the engine whether a new request may be taken. A one-cycle start pulse kicks a transfer from software. A one-cycle termination pulse aborts a transfer. The multi-link bit controls what happens at terminal count. When it is set, the channel keeps running and may take further requests before software has collected the terminal-count flag. When it is clear, the channel disables itself and waits for software to re-enable it and read the flag.

The register bus has no handshake. Every write and every read completes in one cycle, so the block never applies back-pressure. The control and status pins are plain levels or single-cycle pulses.

Top module: `dma_chan_ctrl_bank`

## Requirements
- R1: After reset every channel byte reads 0x00, and all enable, start, termination and accept outputs are low.
- R2: Channel n sits at byte address 2*n. The read data for a request appears on the cycle after it. Each byte returns the terminal-count flag in bit 7, multi-link in bit 3 and enable in bit 0, with bits 6..4, 2 and 1 read as 0. Writes and reads at odd addresses do nothing, and such reads return 0.
- R3: A read of a channel's byte clears its terminal-count flag from the next cycle on.
- R4: A terminal-count pulse sets the flag. When the pulse coincides with a read of the same byte, the flag stays 1.
- R5: With multi-link set, a terminal-count pulse leaves enable at 1.
- R6: With multi-link clear, a terminal-count pulse clears enable.
- R7: Writing 1 to bit 2 clears enable and raises the channel's termination pulse for exactly one cycle.
- R8: Writing 1 to bit 1 raises the start pulse for one cycle only if, before the write, enable was 1 and the flag was 0. Otherwise the write has no effect.
- R9: While the interrupt input is high, every channel's enable clears, and a start write in that cycle produces no pulse.
- R10: A single write that sets both bit 2 and bit 1 produces the termination pulse and no start pulse.
- R11: The request-accept output is high exactly when enable is 1 and either the flag is 0 or multi-link is 1.
- R12: Only bits selected by the write mask change. Writing bit 7 has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_addr | input | 3 | Byte address, channel n at 2*n |
| bus_wdata | input | 8 | Write data |
| bus_wmask | input | 8 | Per-bit write select |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| tc_evt | input | 4 | Per-channel terminal-count pulse |
| nmi | input | 1 | Shared non-maskable interrupt level |
| ch_en | output | 4 | Per-channel enable level |
| ch_start | output | 4 | Per-channel one-cycle software start pulse |
| ch_abort | output | 4 | Per-channel one-cycle forced-termination pulse |
| ch_req_ok | output | 4 | Per-channel request-accept qualifier |

## Verification
The assertions assume that a write and a read never hit the same byte in the same cycle. The keep-enable check also assumes no bus write and no interrupt arrive alongside the terminal-count pulse. The bench issues each bus operation alone. It raises a terminal-count pulse together with a read only in the one scenario aimed at that collision, and never together with a write to the same channel.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_START = 1;
  localparam int unsigned B_ABORT = 2;
  localparam int unsigned B_LINK  = 3;
  localparam int unsigned B_DONE  = 7;

  typedef struct packed {
    logic done;
    logic link;
    logic en;
  } chan_state_t;

  function automatic logic [REG_W-1:0] pack_byte(input chan_state_t s);
    logic [REG_W-1:0] b;
    b         = '0;
    b[B_DONE] = s.done;
    b[B_LINK] = s.link;
    b[B_EN]   = s.en;
    return b;
  endfunction
endpackage

// File: rtl/dcc_addr_dec.sv
module dcc_addr_dec #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 3
) (
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  output logic [NCH-1:0] sel_wr,
  output logic [NCH-1:0] sel_rd
);
  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic hit;
    assign hit       = (bus_addr == AW'(2 * c));
    assign sel_wr[c] = bus_wr & hit;
    assign sel_rd[c] = bus_rd & hit;
  end
endmodule

// File: rtl/dcc_chan_reg.sv
module dcc_chan_reg
  import dcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic              sel_rd,
  input  logic [REG_W-1:0]  wdata,
  input  logic [REG_W-1:0]  wmask,
  input  logic              tc_evt,
  input  logic              nmi,
  output chan_state_t       st,
  output logic              start_p,
  output logic              abort_p,
  output logic              req_ok
);
  chan_state_t st_q, st_n;
  logic        start_q, abort_q;
  logic        wr_en_b, wr_link_b, do_abort, do_start;

  assign wr_en_b   = sel_wr & wmask[B_EN];
  assign wr_link_b = sel_wr & wmask[B_LINK];
  assign do_abort  = sel_wr & wmask[B_ABORT] & wdata[B_ABORT];
  assign do_start  = sel_wr & wmask[B_START] & wdata[B_START]
                   & st_q.en & ~st_q.done & ~do_abort & ~nmi;

  always_comb begin
    st_n      = st_q;
    if (wr_link_b) st_n.link = wdata[B_LINK];
    if (wr_en_b)   st_n.en   = wdata[B_EN];
    if (tc_evt && !st_q.link) st_n.en = 1'b0;
    if (do_abort || nmi)      st_n.en = 1'b0;
    if (sel_rd)    st_n.done = 1'b0;
    if (tc_evt)    st_n.done = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      start_q <= do_start;
      abort_q <= do_abort;
    end
  end

  assign st      = st_q;
  assign start_p = start_q;
  assign abort_p = abort_q;
  assign req_ok  = st_q.en & (~st_q.done | st_q.link);

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rd && !tc_evt) |=> !st.done);
  a_r4_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> st.done);
  a_r5_link_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt && st.link && st.en && !nmi && !sel_wr) |=> st.en);
  a_r6_nolink_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt && !st.link) |=> !st.en);
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && wmask[B_ABORT] && wdata[B_ABORT]) |=> (abort_p && !st.en));
  a_r8_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_p) |-> ($past(st.en) && !$past(st.done)));
  a_r9_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> (!st.en && !start_p));
  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_p && abort_p));
endmodule

// File: rtl/dcc_rd_mux.sv
module dcc_rd_mux
  import dcc_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       sel_rd,
  input  chan_state_t [NCH-1:0] st,
  output logic [REG_W-1:0]     rdata
);
  logic [REG_W-1:0] term [NCH+1];
  logic [REG_W-1:0] rdata_q;

  assign term[0] = '0;
  for (genvar c = 0; c < NCH; c++) begin : g_or
    assign term[c+1] = term[c] | (sel_rd[c] ? pack_byte(st[c]) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= term[NCH];
  end

  assign rdata = rdata_q;

  a_r2_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[6:4] == 3'b000) && (rdata[2:1] == 2'b00));
endmodule

// File: rtl/dma_chan_ctrl_bank.sv
module dma_chan_ctrl_bank
  import dcc_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = $clog2(2 * NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [REG_W-1:0] bus_wmask,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [NCH-1:0]   tc_evt,
  input  logic             nmi,
  output logic [NCH-1:0]   ch_en,
  output logic [NCH-1:0]   ch_start,
  output logic [NCH-1:0]   ch_abort,
  output logic [NCH-1:0]   ch_req_ok
);
  logic [NCH-1:0]        sel_wr, sel_rd;
  chan_state_t [NCH-1:0] st;

  dcc_addr_dec #(.NCH(NCH), .AW(AW)) u_dec (
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .sel_wr  (sel_wr),
    .sel_rd  (sel_rd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dcc_chan_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_wr (sel_wr[c]),
      .sel_rd (sel_rd[c]),
      .wdata  (bus_wdata),
      .wmask  (bus_wmask),
      .tc_evt (tc_evt[c]),
      .nmi    (nmi),
      .st     (st[c]),
      .start_p(ch_start[c]),
      .abort_p(ch_abort[c]),
      .req_ok (ch_req_ok[c])
    );
    assign ch_en[c] = st[c].en;
  end

  dcc_rd_mux #(.NCH(NCH)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_rd(sel_rd),
    .st    (st),
    .rdata (bus_rdata)
  );

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_wr) && $onehot0(sel_rd));
endmodule

// File: tb/sim_dma_chan_ctrl_bank.sv
module sim_dma_chan_ctrl_bank;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_wr = 0, bus_rd = 0, nmi = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_wmask = '0, bus_rdata;
  logic [3:0] tc_evt = '0, ch_en, ch_start, ch_abort, ch_req_ok;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  dma_chan_ctrl_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
    .bus_rdata(bus_rdata), .tc_evt(tc_evt), .nmi(nmi), .ch_en(ch_en),
    .ch_start(ch_start), .ch_abort(ch_abort), .ch_req_ok(ch_req_ok)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [7:0] m);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_wmask = m;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0; bus_wmask = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic tc(input logic [3:0] v);
    tc_evt = v;
    @(negedge clk);
    tc_evt = '0;
  endtask

  task automatic t_reset;
    chk(ch_en == 0 && ch_start == 0 && ch_abort == 0 && ch_req_ok == 0,
        "R1 outputs", {ch_en, ch_start, ch_abort, ch_req_ok}, 0);
    for (int c = 0; c < 4; c++) begin
      rd(3'(2 * c), rv);
      chk(rv == 8'h00, "R1 byte", rv, 0);
    end
  endtask

  task automatic t_layout;
    wr(3'd2, 8'hF9, 8'hFF);
    rd(3'd2, rv);
    chk(rv == 8'h09, "R2 R12 layout and bit7 ignored", rv, 8'h09);
    wr(3'd2, 8'h00, 8'h08);
    rd(3'd2, rv);
    chk(rv == 8'h01, "R12 mask keeps enable", rv, 8'h01);
    wr(3'd3, 8'h01, 8'hFF);
    chk(ch_en == 4'b0010, "R2 odd write ignored", ch_en, 4'b0010);
    rd(3'd3, rv);
    chk(rv == 8'h00, "R2 odd read zero", rv, 0);
  endtask

  task automatic t_start_ok;
    wr(3'd2, 8'h02, 8'h02);
    chk(ch_start == 4'b0010, "R8 start pulse", ch_start, 4'b0010);
    @(negedge clk);
    chk(ch_start == 0, "R8 pulse one cycle", ch_start, 0);
  endtask

  task automatic t_nolink_tc;
    tc(4'b0010);
    chk(ch_en[1] == 0 && ch_req_ok[1] == 0, "R6 R11 enable dropped",
        {ch_en[1], ch_req_ok[1]}, 0);
    wr(3'd2, 8'h03, 8'h03);
    chk(ch_start[1] == 0, "R8 start while disabled", ch_start, 0);
    chk(ch_req_ok[1] == 0, "R11 flag blocks accept", ch_req_ok, 0);
    rd(3'd2, rv);
    chk(rv == 8'h81, "R2 flag visible", rv, 8'h81);
    rd(3'd2, rv);
    chk(rv == 8'h01, "R3 read clears", rv, 8'h01);
    chk(ch_req_ok[1] == 1, "R11 accept after clear", ch_req_ok, 4'b0010);
  endtask

  task automatic t_link_tc;
    wr(3'd4, 8'h09, 8'hFF);
    tc(4'b0100);
    chk(ch_en[2] == 1 && ch_req_ok[2] == 1, "R5 R11 enable kept",
        {ch_en[2], ch_req_ok[2]}, 3);
    wr(3'd4, 8'h02, 8'h02);
    chk(ch_start[2] == 0, "R8 start with flag set", ch_start, 0);
    bus_rd = 1; bus_addr = 3'd4; tc_evt = 4'b0100;
    @(negedge clk);
    bus_rd = 0; tc_evt = '0;
    chk(bus_rdata == 8'h89, "R4 collision read", bus_rdata, 8'h89);
    rd(3'd4, rv);
    chk(rv == 8'h89, "R4 set wins", rv, 8'h89);
    rd(3'd4, rv);
    chk(rv == 8'h09, "R3 cleared after", rv, 8'h09);
  endtask

  task automatic t_abort;
    wr(3'd6, 8'h01, 8'h01);
    wr(3'd6, 8'h06, 8'h06);
    chk(ch_abort == 4'b1000, "R7 R10 abort pulse", ch_abort, 4'b1000);
    chk(ch_start == 0, "R10 start suppressed", ch_start, 0);
    chk(ch_en[3] == 0, "R7 enable cleared", ch_en, 0);
    @(negedge clk);
    chk(ch_abort == 0, "R7 pulse one cycle", ch_abort, 0);
  endtask

  task automatic t_nmi;
    for (int c = 0; c < 4; c++) wr(3'(2 * c), 8'h01, 8'h01);
    chk(ch_en == 4'hF, "R9 all enabled", ch_en, 4'hF);
    nmi = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 8'h02; bus_wmask = 8'h02;
    @(negedge clk);
    nmi = 0; bus_wr = 0;
    chk(ch_en == 0, "R9 all cleared", ch_en, 0);
    chk(ch_start == 0, "R9 start suppressed", ch_start, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_start_ok();
    t_nolink_tc();
    t_link_tc();
    t_abort();
    t_nmi();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule